// File: doc/BRIEF.md
# Four-Stage Shift Register with JK Serial Entry

This block is a small clocked register of four stages (the stage count is a parameter) that either captures a full data word in one step or moves its contents one place along the chain. A mode input picks between the two. When the mode input is high, every stage takes its own bit of the data word on the rising clock edge. When it is low, each stage from the second onward takes the value of the stage before it. The head stage then takes its next value from a two-input JK-style entry network. The entry network can hold, clear, set or toggle the head stage.

The second entry input is active-low. If both entry inputs are driven from one wire, the head stage behaves as a plain D flip-flop fed from that wire. An active-high asynchronous reset clears every stage at once. It overrides loading and shifting for as long as it is held. A polarity input acts directly on the outputs without waiting for a clock. When it is high the outputs show the stored bits, and when it is low they show the inverse of every stored bit.

Typical uses are serial-to-parallel and parallel-to-serial conversion, and small counters or sequence generators in which the entry inputs are driven from the register's own outputs.

Top module: `jk_shift_reg`

## Requirements
- R1: With `load_sel` high, every stage i takes `load_word[i]` on the rising clock edge. Stage 0 is bit 0 and the head of the chain.
- R2: With `load_sel` low, each stage i (for i ≥ 1) takes the previous value of stage i-1 on the rising clock edge.
- R3: In serial mode, `ent_j`=0 with `ent_kn`=1 leaves stage 0 unchanged.
- R4: In serial mode, `ent_j`=0 with `ent_kn`=0 clears stage 0, and `ent_j`=1 with `ent_kn`=1 sets stage 0.
- R5: In serial mode, `ent_j`=1 with `ent_kn`=0 inverts stage 0.
- R6: In serial mode, with `ent_j` and `ent_kn` driven to the same value, stage 0 captures that value, whatever it held before.
- R7: `out_true` high makes `q_out` equal to the stored bits. `out_true` low makes `q_out` their bitwise inverse. A change of `out_true` reaches `q_out` without any clock edge.
- R8: `rst` high clears all stages at once, without a clock edge, and keeps them cleared through clock edges whatever the mode and data inputs are.
- R9: The stored bits change only on a rising clock edge. Changing `load_sel`, `load_word`, `ent_j` or `ent_kn` between edges leaves `q_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all transfers on the rising edge |
| rst | input | 1 | Asynchronous active-high clear of all stages |
| load_sel | input | 1 | 1 = parallel load, 0 = serial shift |
| load_word | input | 4 | Parallel data, bit i feeds stage i |
| ent_j | input | 1 | JK entry input J for stage 0 |
| ent_kn | input | 1 | JK entry input K, active-low |
| out_true | input | 1 | 1 = true outputs, 0 = complemented outputs |
| q_out | output | 4 | Stage contents, or their inverse, bit i from stage i |

## Verification
A load or a shift is due one rising edge after its inputs are applied. The bench therefore drives inputs at the falling edge and reads `q_out` one nanosecond after the next rising edge, before the next drive. The results of reset and polarity are due at once, with no edge. The bench changes `rst` or `out_true` shortly after a rising edge and reads the outputs in the same half-cycle, before any further edge can occur. For the hold rule (R9), the bench changes data and mode inputs between edges and confirms that `q_out` has not moved before the next edge arrives.

// File: rtl/jk_shift_pkg.sv
package jk_shift_pkg;
  typedef enum logic [1:0] {
    ENT_CLEAR  = 2'b00,
    ENT_HOLD   = 2'b01,
    ENT_TOGGLE = 2'b10,
    ENT_SET    = 2'b11
  } ent_action_e;

  function automatic ent_action_e decode_entry(input logic j, input logic kn);
    return ent_action_e'({j, kn});
  endfunction
endpackage

// File: rtl/jk_entry.sv
module jk_entry
  import jk_shift_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic serial_en,
  input  logic j,
  input  logic kn,
  input  logic cur,
  output logic nxt
);
  ent_action_e act;

  always_comb begin
    act = decode_entry(j, kn);
    unique case (act)
      ENT_CLEAR:  nxt = 1'b0;
      ENT_HOLD:   nxt = cur;
      ENT_TOGGLE: nxt = ~cur;
      ENT_SET:    nxt = 1'b1;
      default:    nxt = cur;
    endcase
  end

  // R3
  ent_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (serial_en && !j && kn) |=> (cur == $past(cur)));
  // R5
  ent_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (serial_en && j && !kn) |=> (cur != $past(cur)));
  // R6
  ent_tied_chk: assert property (@(posedge clk) disable iff (rst)
    (serial_en && (j == kn)) |=> (cur == $past(j)));
endmodule

// File: rtl/stage_chain.sv
module stage_chain #(
  parameter int STAGES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_sel,
  input  logic [STAGES-1:0] load_word,
  input  logic              head_nxt,
  output logic [STAGES-1:0] q
);
  localparam int LAST = STAGES - 1;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      logic d;
      if (i == 0) begin : g_head
        assign d = load_sel ? load_word[0] : head_nxt;
      end else begin : g_body
        assign d = load_sel ? load_word[i] : q[i-1];
      end
      always_ff @(posedge clk or posedge rst) begin
        if (rst) q[i] <= 1'b0;
        else     q[i] <= d;
      end
    end
  endgenerate

  // R1
  par_load_chk: assert property (@(posedge clk) disable iff (rst)
    load_sel |=> (q == $past(load_word)));
  // R2
  shift_move_chk: assert property (@(posedge clk) disable iff (rst)
    !load_sel |=> (q[LAST:1] == $past(q[LAST-1:0])));
  // R8
  reset_hold_chk: assert property (@(posedge clk)
    rst |=> (q == '0));
endmodule

// File: rtl/out_polarity.sv
module out_polarity #(
  parameter int STAGES = 4
) (
  input  logic              out_true,
  input  logic [STAGES-1:0] q,
  output logic [STAGES-1:0] q_out
);
  localparam logic [STAGES-1:0] ALL_ONES = '1;

  always_comb q_out = out_true ? q : (q ^ ALL_ONES);
endmodule

// File: rtl/jk_shift_reg.sv
module jk_shift_reg #(
  parameter int STAGES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_sel,
  input  logic [STAGES-1:0] load_word,
  input  logic              ent_j,
  input  logic              ent_kn,
  input  logic              out_true,
  output logic [STAGES-1:0] q_out
);
  logic [STAGES-1:0] q_state;
  logic              head_nxt;

  jk_entry u_entry (
    .clk       (clk),
    .rst       (rst),
    .serial_en (!load_sel),
    .j         (ent_j),
    .kn        (ent_kn),
    .cur       (q_state[0]),
    .nxt       (head_nxt)
  );

  stage_chain #(.STAGES(STAGES)) u_chain (
    .clk       (clk),
    .rst       (rst),
    .load_sel  (load_sel),
    .load_word (load_word),
    .head_nxt  (head_nxt),
    .q         (q_state)
  );

  out_polarity #(.STAGES(STAGES)) u_pol (
    .out_true (out_true),
    .q        (q_state),
    .q_out    (q_out)
  );

  // R7
  polarity_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(q_out ^ q_state) == (out_true ? 0 : STAGES)));
  // R4
  ent_force_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_sel && (ent_j == ent_kn)) |=> (q_state[0] == $past(ent_j)));
endmodule

// File: tb/jk_shift_reg_tb.sv
module jk_shift_reg_tb;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst;
  logic         load_sel;
  logic [W-1:0] load_word;
  logic         ent_j;
  logic         ent_kn;
  logic         out_true;
  logic [W-1:0] q_out;

  int n_checks = 0;
  int n_fail   = 0;
  logic [W-1:0] mdl;
  bit done = 0;

  always #2 clk = ~clk;

  jk_shift_reg #(.STAGES(W)) u_dut (
    .clk(clk), .rst(rst), .load_sel(load_sel), .load_word(load_word),
    .ent_j(ent_j), .ent_kn(ent_kn), .out_true(out_true), .q_out(q_out)
  );

  task automatic check(input string req, input logic [W-1:0] exp);
    n_checks++;
    if (q_out !== exp) begin
      n_fail++;
      $display("FAIL %s: q_out=%b expected=%b", req, q_out, exp);
    end
  endtask

  function automatic logic [W-1:0] seen(input logic [W-1:0] s, input logic t);
    return t ? s : ~s;
  endfunction

  function automatic logic [W-1:0] next_model(input logic [W-1:0] s, input logic ld,
                                              input logic [W-1:0] w, input logic j,
                                              input logic kn);
    logic h;
    if (ld) return w;
    case ({j, kn})
      2'b00: h = 1'b0;
      2'b01: h = s[0];
      2'b10: h = ~s[0];
      default: h = 1'b1;
    endcase
    return {s[W-2:0], h};
  endfunction

  task automatic step(input logic ld, input logic [W-1:0] w, input logic j,
                      input logic kn, input string req);
    @(negedge clk);
    load_sel = ld; load_word = w; ent_j = j; ent_kn = kn;
    @(posedge clk); #1;
    mdl = next_model(mdl, ld, w, j, kn);
    check(req, seen(mdl, out_true));
  endtask

  initial begin
    #200000;
    n_fail++; n_checks++;
    $display("FAIL watchdog: q_out=%b expected=finish", q_out);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst = 1'b1; load_sel = 1'b0; load_word = '0; ent_j = 1'b0; ent_kn = 1'b1;
    out_true = 1'b1;
    mdl = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R8 reset state", '0);
    @(negedge clk); rst = 1'b0;

    // R1 parallel load sweep, both polarities
    for (int t = 0; t < 2; t++) begin
      out_true = t[0];
      for (int v = 0; v < 16; v++) step(1'b1, v[W-1:0], 1'b0, 1'b1, "R1 load");
    end
    out_true = 1'b1;

    // R3/R4/R5 entry combos from both head states
    for (int s0 = 0; s0 < 2; s0++) begin
      for (int c = 0; c < 4; c++) begin
        step(1'b1, {3'b101, s0[0]}, 1'b0, 1'b1, "R1 preload");
        step(1'b0, 4'h0, c[1], c[0],
             (c == 1) ? "R3 hold" : (c == 2) ? "R5 toggle" : "R4 clear/set");
      end
    end

    // R6 tied inputs act as D, R2 multi-cycle shifting
    step(1'b1, 4'b0110, 1'b0, 1'b1, "R1 preload");
    for (int k = 0; k < 12; k++) begin
      logic b;
      b = ((k * 5 + 1) % 3) == 0;
      step(1'b0, 4'h0, b, b, "R6 tied D / R2 shift");
    end
    for (int k = 0; k < 6; k++) step(1'b0, 4'h0, 1'b1, 1'b0, "R2 shift with toggle");

    // R7 polarity between edges
    step(1'b1, 4'b1001, 1'b0, 1'b1, "R1 preload");
    @(posedge clk); #1;
    out_true = 1'b0; #0.5;
    check("R7 complement no edge", ~mdl);
    out_true = 1'b1; #0.5;
    check("R7 true no edge", mdl);

    // R9 inputs change between edges without effect
    @(negedge clk);
    load_sel = 1'b1; load_word = 4'b0110; ent_j = 1'b1; ent_kn = 1'b0;
    #1;
    check("R9 no change before edge", seen(mdl, out_true));
    @(posedge clk); #1;
    mdl = 4'b0110;
    check("R1 load after edge", mdl);

    // R8 reset mid-operation, then held over edges
    step(1'b0, 4'h0, 1'b1, 1'b1, "R2 shift before reset");
    rst = 1'b1; #0.5;
    mdl = '0;
    check("R8 async clear", '0);
    load_sel = 1'b1; load_word = 4'b1111;
    repeat (2) @(posedge clk);
    #1;
    check("R8 held over load", '0);
    out_true = 1'b0; #0.5;
    check("R8/R7 cleared inverse", 4'b1111);
    out_true = 1'b1;
    @(negedge clk); rst = 1'b0;
    step(1'b1, 4'b1010, 1'b0, 1'b1, "R1 after reset");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule